// File: doc/BRIEF.md
# Synchronous Memory Bus Bridge for an 8-bit CPU

This block connects an 8-bit processor core with a 16-bit address bus to on-chip memory regions built from synchronous-read RAM: a lower memory region, an upper memory region and a small peripheral window. Address decode, chip selects and write strobes are combinational from the live address, so a store reaches its region in the same cycle the core drives it. Read data comes back one cycle later from memory output registers. The bridge steers that data with a copy of the region choice that was registered when the address was issued. It does not use the address currently on the bus, because that address has already moved on.

The core can be stalled with a ready input. During a stall the core may reuse incoming data as part of its next address. The data presented to the core is therefore frozen for as long as ready stays low. The registered region choice is also frozen, so a stalled access keeps its source. Reads of locations that cannot be read return all ones. This covers the write-only top of the peripheral window and, when the upper region is disabled by parameter, the unmapped upper half.

Top module: `syncmem_bus_bridge`

## Requirements
- R1: Regions are decoded from the live address. The lower region covers 0x0000 to 0x7FFF. The upper region covers 0x8000 to 0xFFFF, except 0xFE00 to 0xFEFF, which selects only the peripheral window. Exactly one of `lo_cs`, `hi_cs`, `per_cs` is high in every cycle.
- R2: When `cpu_we` and `cpu_rdy` are both high, the strobe of the selected region (`lo_we`, `hi_we` or `per_we`) is high in that same cycle and no other strobe is. `mem_addr` and `mem_wdata` equal `cpu_addr` and `cpu_wdata`. A store to 0x0D00 lands at lower-region offset 0xD00 and leaves offset 0x000 untouched.
- R3: A store presented while `cpu_rdy` is low raises no write strobe and changes no memory.
- R4: If an address is presented in cycle N with `cpu_rdy` high, `cpu_rdata` in cycle N+1 carries the read data of the region that address selected in cycle N.
- R5: The registered region choice changes only on edges where `cpu_rdy` is high. After a stall spent on addresses in other regions, the data shown is still from the region of the last accepted access.
- R6: In every cycle that follows a cycle with `cpu_rdy` low, `cpu_rdata` equals its value in that low cycle.
- R7: When `cpu_rdy` is high for a single cycle between stalls, the access in that cycle delivers its data in the next cycle, and that data stays on `cpu_rdata` through the following stall.
- R8: Peripheral offsets 0xF0 to 0xFF are write-only. Reads of them return 0xFF, and writes to them still raise `per_we`.
- R9: Reset clears the registered region choice and the held data, so `cpu_rdata` is 0x00 until the first access accepted with `cpu_rdy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Address from the core |
| cpu_wdata | input | 8 | Store data from the core |
| cpu_we | input | 1 | Store request from the core |
| cpu_rdy | input | 1 | Ready; low stalls the core |
| cpu_rdata | output | 8 | Data presented to the core |
| mem_addr | output | 16 | Address forwarded to all regions |
| mem_wdata | output | 8 | Store data forwarded to all regions |
| lo_cs | output | 1 | Lower region select |
| lo_we | output | 1 | Lower region write strobe |
| hi_cs | output | 1 | Upper region select |
| hi_we | output | 1 | Upper region write strobe |
| per_cs | output | 1 | Peripheral window select |
| per_we | output | 1 | Peripheral window write strobe |
| lo_rdata | input | 8 | Registered read data of the lower region |
| hi_rdata | input | 8 | Registered read data of the upper region |
| per_rdata | input | 8 | Registered read data of the peripheral window |

## Verification
The assertions assume that the core inputs carry known values in every cycle after reset. They also assume each region's read data comes from a register clocked by the same edge that samples the address, since the stall-hold and region-freeze properties compare values one edge apart. The stimulus changes every input only at the falling clock edge. Its memory models register read data on the rising edge, one cycle after the address. Random addresses are biased toward the peripheral window, and ready is dropped often, including single-cycle ready pulses, so stalls hit every region.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_LO   = 2'd1,
      RSEL_HI   = 2'd2,
      RSEL_PER  = 2'd3
   } rsel_e;

   typedef struct packed {
      logic  hit_lo;
      logic  hit_hi;
      logic  hit_per;
      rsel_e rsel;
   } decode_t;

endpackage

// File: rtl/bridge_decode.sv
module bridge_decode
   import bridge_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int HI_BASE      = 32'h8000,
   parameter int HAS_HI       = 1,
   parameter int PER_BASE     = 32'hFE00,
   parameter int PER_WIN_LOG2 = 8,
   parameter int WO_OFFSET    = 32'hF0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output decode_t           dec_o
);

   localparam int PER_LSB  = PER_WIN_LOG2;
   localparam int PER_SPAN = 1 << PER_WIN_LOG2;
   localparam int TAG_W    = ADDR_W - PER_LSB;
   localparam logic [ADDR_W-1:0] HI_BASE_V  = ADDR_W'(HI_BASE);
   localparam logic [ADDR_W-1:0] PER_BASE_V = ADDR_W'(PER_BASE);
   localparam logic [TAG_W-1:0]  PER_TAG    = PER_BASE_V[ADDR_W-1:PER_LSB];
   localparam logic [PER_LSB:0]  WO_V       = (PER_LSB+1)'(WO_OFFSET);

   // elaboration-time parameter checks
   if (PER_WIN_LOG2 < 1 || PER_WIN_LOG2 >= ADDR_W) begin : g_bad_win
      $error("bridge_decode: window size out of range");
   end
   if ((PER_BASE % PER_SPAN) != 0) begin : g_bad_align
      $error("bridge_decode: window base not aligned to its size");
   end
   if (WO_OFFSET > PER_SPAN || WO_OFFSET < 0) begin : g_bad_wo
      $error("bridge_decode: write-only offset beyond window");
   end
   if (HI_BASE <= 0 || HI_BASE >= (1 << ADDR_W)) begin : g_bad_split
      $error("bridge_decode: region split outside address space");
   end

   logic upper_hit;
   logic lower_hit;
   logic win_hit;
   logic wo_hit;

   assign lower_hit = (addr_i < HI_BASE_V);
   assign win_hit   = (addr_i[ADDR_W-1:PER_LSB] == PER_TAG);

   if (HAS_HI != 0) begin : g_upper
      assign upper_hit = (addr_i >= HI_BASE_V);
   end else begin : g_no_upper
      assign upper_hit = 1'b0;
   end

   if (WO_OFFSET < PER_SPAN) begin : g_wo
      assign wo_hit = ({1'b0, addr_i[PER_LSB-1:0]} >= WO_V);
   end else begin : g_no_wo
      assign wo_hit = 1'b0;
   end

   always_comb begin
      dec_o.hit_per = win_hit;
      dec_o.hit_hi  = upper_hit & ~win_hit;
      dec_o.hit_lo  = lower_hit & ~win_hit;
      if (win_hit) begin
         dec_o.rsel = wo_hit ? RSEL_NONE : RSEL_PER;
      end else if (upper_hit) begin
         dec_o.rsel = RSEL_HI;
      end else if (lower_hit) begin
         dec_o.rsel = RSEL_LO;
      end else begin
         dec_o.rsel = RSEL_NONE;
      end
   end

endmodule

// File: rtl/bridge_wr_steer.sv
module bridge_wr_steer
   import bridge_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  decode_t dec_i,
   input  logic    we_i,
   input  logic    rdy_i,
   output logic    lo_cs_o,
   output logic    hi_cs_o,
   output logic    per_cs_o,
   output logic    lo_we_o,
   output logic    hi_we_o,
   output logic    per_we_o
);

   logic wr_go;

   assign wr_go    = we_i & rdy_i;
   assign lo_cs_o  = dec_i.hit_lo;
   assign hi_cs_o  = dec_i.hit_hi;
   assign per_cs_o = dec_i.hit_per;
   assign lo_we_o  = wr_go & dec_i.hit_lo;
   assign hi_we_o  = wr_go & dec_i.hit_hi;
   assign per_we_o = wr_go & dec_i.hit_per;

   // R2
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lo_we_o, hi_we_o, per_we_o}));

   // R3
   stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_i |-> !(lo_we_o || hi_we_o || per_we_o));

   // R1
   window_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_cs_o |-> !hi_cs_o);

endmodule

// File: rtl/bridge_rd_path.sv
module bridge_rd_path
   import bridge_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rdy_i,
   input  rsel_e             rsel_i,
   input  logic [DATA_W-1:0] lo_rd_i,
   input  logic [DATA_W-1:0] hi_rd_i,
   input  logic [DATA_W-1:0] per_rd_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [DATA_W-1:0] FILL = '1;

   if (DATA_W < 1) begin : g_bad_width
      $error("bridge_rd_path: data width must be positive");
   end

   rsel_e             sel_q;
   logic              fresh_q;
   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] mux_out;

   always_comb begin
      case (sel_q)
         RSEL_LO:  mux_out = lo_rd_i;
         RSEL_HI:  mux_out = hi_rd_i;
         RSEL_PER: mux_out = per_rd_i;
         default:  mux_out = FILL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= RSEL_NONE;
         fresh_q <= 1'b0;
         hold_q  <= '0;
      end else begin
         fresh_q <= rdy_i;
         if (rdy_i) begin
            sel_q <= rsel_i;
         end
         if (fresh_q) begin
            hold_q <= mux_out;
         end
      end
   end

   assign rdata_o = fresh_q ? mux_out : hold_q;

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_i |=> $stable(rdata_o));

   // R5
   sel_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_i |=> $stable(sel_q));

endmodule

// File: rtl/syncmem_bus_bridge.sv
module syncmem_bus_bridge
   import bridge_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 8,
   parameter int HI_BASE      = 32'h8000,
   parameter int HAS_HI       = 1,
   parameter int PER_BASE     = 32'hFE00,
   parameter int PER_WIN_LOG2 = 8,
   parameter int WO_OFFSET    = 32'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_we,
   input  logic              cpu_rdy,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              lo_cs,
   output logic              lo_we,
   output logic              hi_cs,
   output logic              hi_we,
   output logic              per_cs,
   output logic              per_we,
   input  logic [DATA_W-1:0] lo_rdata,
   input  logic [DATA_W-1:0] hi_rdata,
   input  logic [DATA_W-1:0] per_rdata
);

   decode_t dec;

   assign mem_addr  = cpu_addr;
   assign mem_wdata = cpu_wdata;

   bridge_decode #(
      .ADDR_W       (ADDR_W),
      .HI_BASE      (HI_BASE),
      .HAS_HI       (HAS_HI),
      .PER_BASE     (PER_BASE),
      .PER_WIN_LOG2 (PER_WIN_LOG2),
      .WO_OFFSET    (WO_OFFSET)
   ) u_decode (
      .addr_i (cpu_addr),
      .dec_o  (dec)
   );

   bridge_wr_steer u_wr_steer (
      .clk      (clk),
      .rst_n    (rst_n),
      .dec_i    (dec),
      .we_i     (cpu_we),
      .rdy_i    (cpu_rdy),
      .lo_cs_o  (lo_cs),
      .hi_cs_o  (hi_cs),
      .per_cs_o (per_cs),
      .lo_we_o  (lo_we),
      .hi_we_o  (hi_we),
      .per_we_o (per_we)
   );

   bridge_rd_path #(
      .DATA_W (DATA_W)
   ) u_rd_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .rdy_i    (cpu_rdy),
      .rsel_i   (dec.rsel),
      .lo_rd_i  (lo_rdata),
      .hi_rd_i  (hi_rdata),
      .per_rd_i (per_rdata),
      .rdata_o  (cpu_rdata)
   );

   // R1
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_HI == 0) || $onehot({lo_cs, hi_cs, per_cs}));

endmodule

// File: tb/syncmem_bus_bridge_tb.sv
module syncmem_bus_bridge_tb;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic [15:0] cpu_addr;
   logic [7:0]  cpu_wdata;
   logic        cpu_we;
   logic        cpu_rdy;
   logic [7:0]  cpu_rdata;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        lo_cs, lo_we, hi_cs, hi_we, per_cs, per_we;
   logic [7:0]  lo_rdata, hi_rdata, per_rdata;

   syncmem_bus_bridge u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_we    (cpu_we),
      .cpu_rdy   (cpu_rdy),
      .cpu_rdata (cpu_rdata),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .lo_cs     (lo_cs),
      .lo_we     (lo_we),
      .hi_cs     (hi_cs),
      .hi_we     (hi_we),
      .per_cs    (per_cs),
      .per_we    (per_we),
      .lo_rdata  (lo_rdata),
      .hi_rdata  (hi_rdata),
      .per_rdata (per_rdata)
   );

   localparam int SALT_LO = 11, SALT_HI = 97, SALT_PER = 173;

   function automatic logic [7:0] hash(input int i, input int salt);
      return 8'(i * 37 + salt) ^ 8'(i >>> 3);
   endfunction

   // synchronous-read memory models, read-before-write
   logic [7:0] mem_lo  [4096];
   logic [7:0] mem_hi  [4096];
   logic [7:0] mem_per [256];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4096; i++) begin
            mem_lo[i] <= hash(i, SALT_LO);
            mem_hi[i] <= hash(i, SALT_HI);
         end
         for (int i = 0; i < 256; i++) mem_per[i] <= hash(i, SALT_PER);
         lo_rdata <= 8'h00; hi_rdata <= 8'h00; per_rdata <= 8'h00;
      end else begin
         if (lo_cs) begin
            lo_rdata <= mem_lo[mem_addr[11:0]];
            if (lo_we) mem_lo[mem_addr[11:0]] <= mem_wdata;
         end
         if (hi_cs) begin
            hi_rdata <= mem_hi[mem_addr[11:0]];
            if (hi_we) mem_hi[mem_addr[11:0]] <= mem_wdata;
         end
         if (per_cs) begin
            per_rdata <= mem_per[mem_addr[7:0]];
            if (per_we) mem_per[mem_addr[7:0]] <= mem_wdata;
         end
      end
   end

   // shadow contents kept from the requirements
   logic [7:0] sh_lo  [4096];
   logic [7:0] sh_hi  [4096];
   logic [7:0] sh_per [256];

   int checks = 0;
   int errors = 0;
   logic [7:0] expect_q = 8'h00;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // 1 = lower, 2 = upper, 3 = peripheral window
   function automatic int region(input logic [15:0] a);
      if (a[15:8] == 8'hFE) return 3;
      if (a[15]) return 2;
      return 1;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [15:0] a);
      case (region(a))
         3:       return (a[7:0] >= 8'hF0) ? 8'hFF : sh_per[a[7:0]];
         2:       return sh_hi[a[11:0]];
         default: return sh_lo[a[11:0]];
      endcase
   endfunction

   task automatic step(input logic [15:0] a, input bit w, input logic [7:0] d,
                       input bit r, input string tag = "");
      logic [2:0] exp_cs;
      logic [2:0] exp_we;
      logic [7:0] next_exp;
      int rg;
      cpu_addr = a; cpu_we = w; cpu_wdata = d; cpu_rdy = r;
      #1;
      rg = region(a);
      exp_cs = (rg == 3) ? 3'b100 : (rg == 2) ? 3'b010 : 3'b001;
      exp_we = (w && r) ? exp_cs : 3'b000;
      chk({per_cs, hi_cs, lo_cs} == exp_cs, "R1", 32'({per_cs, hi_cs, lo_cs}), 32'(exp_cs));
      chk({per_we, hi_we, lo_we} == exp_we, (w && !r) ? "R3" : "R2",
          32'({per_we, hi_we, lo_we}), 32'(exp_we));
      chk(mem_addr == a && mem_wdata == d, "R2", 32'({mem_addr, mem_wdata}), 32'({a, d}));
      next_exp = r ? exp_rd(a) : expect_q;
      if (w && r) begin
         case (rg)
            3:       sh_per[a[7:0]] = d;
            2:       sh_hi[a[11:0]] = d;
            default: sh_lo[a[11:0]] = d;
         endcase
      end
      @(negedge clk);
      chk(cpu_rdata == next_exp, (tag != "") ? tag : (r ? "R4" : "R6"),
          32'(cpu_rdata), 32'(next_exp));
      expect_q = next_exp;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd7321);
      for (int i = 0; i < 4096; i++) begin
         sh_lo[i] = hash(i, SALT_LO);
         sh_hi[i] = hash(i, SALT_HI);
      end
      for (int i = 0; i < 256; i++) sh_per[i] = hash(i, SALT_PER);

      rst_n = 1'b0; cpu_addr = 16'h0; cpu_wdata = 8'h0; cpu_we = 1'b0; cpu_rdy = 1'b0;
      repeat (3) @(negedge clk);
      chk(cpu_rdata == 8'h00, "R9", 32'(cpu_rdata), 32'h0);
      rst_n = 1'b1;
      step(16'h1234, 1'b0, 8'h00, 1'b0, "R9");

      // R2: store to 0x0D00 then load it back
      step(16'h0D00, 1'b1, 8'h5A, 1'b1);
      step(16'h0D00, 1'b0, 8'h00, 1'b1);
      chk(cpu_rdata == 8'h5A, "R2", 32'(cpu_rdata), 32'h5A);
      chk(mem_lo[12'hD00] == 8'h5A, "R2", 32'(mem_lo[12'hD00]), 32'h5A);
      chk(mem_lo[12'h000] == hash(0, SALT_LO), "R2", 32'(mem_lo[12'h000]), 32'(hash(0, SALT_LO)));
      step(16'h0000, 1'b0, 8'h00, 1'b1);

      // R1: window has priority over upper region
      step(16'hFE10, 1'b1, 8'hC3, 1'b1);
      step(16'hFE10, 1'b0, 8'h00, 1'b1);
      chk(mem_hi[12'hE10] == sh_hi[12'hE10], "R1", 32'(mem_hi[12'hE10]), 32'(sh_hi[12'hE10]));
      chk(cpu_rdata == 8'hC3, "R1", 32'(cpu_rdata), 32'hC3);

      // R8: write-only window offsets
      step(16'hFEF5, 1'b1, 8'h33, 1'b1);
      chk(mem_per[8'hF5] == 8'h33, "R8", 32'(mem_per[8'hF5]), 32'h33);
      step(16'hFEF5, 1'b0, 8'h00, 1'b1);
      chk(cpu_rdata == 8'hFF, "R8", 32'(cpu_rdata), 32'hFF);

      // R5 / R3: stall on other regions after a window read
      step(16'hFE20, 1'b0, 8'h00, 1'b1);
      step(16'h9000, 1'b0, 8'h00, 1'b0, "R5");
      step(16'h0100, 1'b1, 8'h77, 1'b0, "R5");
      step(16'hA0A0, 1'b0, 8'h00, 1'b0, "R5");
      chk(mem_lo[12'h100] == sh_lo[12'h100], "R3", 32'(mem_lo[12'h100]), 32'(sh_lo[12'h100]));

      // R7: single-cycle ready pulses between stalls
      step(16'h2000, 1'b0, 8'h00, 1'b0);
      step(16'h8123, 1'b0, 8'h00, 1'b1, "R7");
      step(16'h3000, 1'b0, 8'h00, 1'b0, "R7");
      step(16'hFE01, 1'b0, 8'h00, 1'b0, "R7");
      step(16'hFE01, 1'b0, 8'h00, 1'b1, "R7");
      step(16'h0040, 1'b0, 8'h00, 1'b0, "R7");
      step(16'h0D00, 1'b0, 8'h00, 1'b1, "R7");
      step(16'hC000, 1'b0, 8'h00, 1'b0, "R7");

      // constrained random traffic
      for (int n = 0; n < 800; n++) begin
         logic [15:0] a;
         bit w, r;
         a = (($urandom % 4) == 0) ? {8'hFE, 8'($urandom)} : 16'($urandom);
         w = (($urandom % 10) < 3);
         r = (($urandom % 10) < 7);
         step(a, w, 8'($urandom), r);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule